// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is a slave serial control port in front of a bank of thirty-two 8-bit configuration registers. A host pulls chip select low, clocks in an instruction byte, and then moves one to four data bytes. The instruction byte carries a read/write flag, a two-bit length field and a five-bit start address. After each data byte an internal address generator steps to the next register. The port is configured through register 0, and a new configuration takes effect for the very next bit after the byte that changes it. The bit order picks both how bits are shifted and which way the address steps. The wire mode picks whether read data leaves on the shared data pin or on a separate output. A reset bit in register 0 restores every other register to its default value. A write pattern that reads the same in either bit order lets a host regain control after it has lost track of the port's configuration.

The serial inputs are taken to be synchronous to `clk` and much slower than it. SCLK edges are found by comparing SCLK with its value one clock earlier. The host must give at least one `clk` cycle between the fall of chip select and the first SCLK edge. Input bits are captured on SCLK rising edges. Read data changes only on SCLK falling edges. The whole register bank is visible in parallel on `reg_flat`, where register k occupies bits [8k+7:8k].

The controller has four named states. IDLE is entered whenever chip select is high. IDLE goes to INSTR once chip select is low. INSTR goes to DATA on the eighth rising edge. DATA goes to DONE on the last rising edge of the final data byte. DONE holds until chip select rises. Any state returns to IDLE when chip select is high.

Top module: `serport_top`

## Requirements
- R1: The instruction byte, in MSB-to-LSB order, is R/W (1 = read), N1, N0, A4..A0. The transfer moves N1:N0 + 1 data bytes. The first byte goes to address A4..A0. A write changes only the addressed registers.
- R2: When register 0 bit 6 is 0 (MSB-first), every byte is shifted most significant bit first, and the address decrements by one after each data byte.
- R3: When register 0 bit 6 is 1 (LSB-first), every byte is shifted least significant bit first, and the address increments by one after each data byte.
- R4: The address wraps from 0x1F to 0x00 when incrementing and from 0x00 to 0x1F when decrementing, for both reads and writes.
- R5: A write to register 0 changes the bit order (bit 6) and the wire mode (bit 7) starting with the next byte of the same transfer. The step after that byte already follows the new bit order.
- R6: Writing register 0 with bit 5 set returns registers 1 to 31 to their defaults. Register 0 keeps the written bits 7, 6 and 4..0, and bit 5 always reads as 0.
- R7: A register 0 write with the palindromic pattern XY1001YX, sent with instruction 0x00, is taken correctly whether the port is currently MSB-first or LSB-first. It sets bit 7 = X and bit 6 = Y and resets registers 1 to 31.
- R8: During the data phase of a read, the port behaves according to register 0 bit 7. When bit 7 is 0 (3-wire), `sdio_oe` is 1 and data appears on `sdio_out`. When bit 7 is 1 (4-wire), `sdo_oe` is 1 and data appears on `sdo`. Each bit changes only on an SCLK falling edge and is valid at the following rising edge.
- R9: Raising chip select in the middle of a transfer aborts it without writing anything. The next transfer starts again with an instruction byte.
- R10: After `rst_n`, register 0 is 0x00 (MSB-first, 3-wire). Register k (k = 1..31) holds ((k*29) mod 256) XOR 0xA5. Both output enables are 0.
- R11: A read returns each register's contents as they stand when that byte begins. It uses the same bit order and address stepping as a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| sclk | input | 1 | Serial clock |
| sdio_in | input | 1 | Serial data in, shared data pin input side |
| sdio_out | output | 1 | Read data toward the shared data pin |
| sdio_oe | output | 1 | Drive enable for the shared data pin (3-wire read) |
| sdo | output | 1 | Separate read data output (4-wire read) |
| sdo_oe | output | 1 | Drive enable for the separate output |
| reg_flat | output | 256 | All 32 registers, register k at bits [8k+7:8k] |

## Verification
An SCLK edge applied at a falling `clk` edge is detected at the next rising `clk` edge. A read bit launched there is stable three `clk` cycles before the following SCLK rise, so the monitor samples `sdio_out` or `sdo` exactly on that rise, well away from any `clk` edge. A written byte reaches the bank two `clk` edges after its eighth SCLK rise, and a new port configuration takes effect at the same moment. The next SCLK edge comes four cycles later, so the bench's model switches its bit order at the byte boundary, just as the port does. The parallel bank is compared only after chip select has been high for several cycles, when every write has settled.

// File: rtl/serport_pkg.sv
package serport_pkg;

    localparam int SP_DATA_W   = 8;
    localparam int CFG_4W_BIT  = 7;
    localparam int CFG_LSB_BIT = 6;
    localparam int CFG_RST_BIT = 5;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_INSTR = 2'd1,
        S_DATA  = 2'd2,
        S_DONE  = 2'd3
    } sp_state_t;

    // Power-up value of register idx; register 0 starts at zero.
    function automatic logic [SP_DATA_W-1:0] reg_default(input int idx);
        logic [SP_DATA_W-1:0] prod;
        prod = SP_DATA_W'(idx * 29);
        return (idx == 0) ? '0 : (prod ^ SP_DATA_W'(8'hA5));
    endfunction

endpackage

// File: rtl/serport_regbank.sv
module serport_regbank
    import serport_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [SP_DATA_W-1:0]          wr_data,
    input  logic [ADDR_W-1:0]             rd_addr,
    output logic [SP_DATA_W-1:0]          rd_data,
    output logic                          cfg_lsb,
    output logic                          cfg_4w,
    output logic [(1<<ADDR_W)*SP_DATA_W-1:0] reg_flat
);
    localparam int NREG = 1 << ADDR_W;

    logic [SP_DATA_W-1:0] bank [NREG];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) bank[i] <= reg_default(i);
        end else if (wr_en) begin
            if (wr_addr == '0) begin
                bank[0] <= wr_data & ~(SP_DATA_W'(1) << CFG_RST_BIT);
                if (wr_data[CFG_RST_BIT]) begin
                    for (int i = 1; i < NREG; i++) bank[i] <= reg_default(i);
                end
            end else begin
                bank[wr_addr] <= wr_data;
            end
        end
    end

    assign rd_data = bank[rd_addr];
    assign cfg_lsb = bank[0][CFG_LSB_BIT];
    assign cfg_4w  = bank[0][CFG_4W_BIT];

    for (genvar g = 0; g < NREG; g++) begin : g_flat
        assign reg_flat[g*SP_DATA_W +: SP_DATA_W] = bank[g];
    end

    // A plain write lands in the addressed register on the next edge.
    assert_write_lands_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != '0) |=> bank[$past(wr_addr)] == $past(wr_data));

    // New configuration is visible right after the register 0 write.
    assert_cfg_update_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == '0) |=> (cfg_lsb == $past(wr_data[CFG_LSB_BIT]) &&
                                       cfg_4w  == $past(wr_data[CFG_4W_BIT])));

    // Software reset restores the top register to its default.
    assert_soft_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == '0 && wr_data[CFG_RST_BIT]) |=>
            (bank[NREG-1] == reg_default(NREG-1) && !bank[0][CFG_RST_BIT]));

endmodule

// File: rtl/serport_fsm.sv
module serport_fsm
    import serport_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int CNT_W  = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cs_n,
    input  logic                 sclk,
    input  logic                 sdi,
    input  logic                 cfg_lsb,
    input  logic                 cfg_4w,
    input  logic [SP_DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0]    rd_addr,
    output logic                 wr_en,
    output logic [ADDR_W-1:0]    wr_addr,
    output logic [SP_DATA_W-1:0] wr_data,
    output logic                 dout,
    output logic                 sdio_oe,
    output logic                 sdo_oe
);
    localparam int BIT_W  = $clog2(SP_DATA_W);
    localparam int RW_POS = SP_DATA_W - 1;
    localparam int N_LO   = ADDR_W;
    localparam int N_HI   = ADDR_W + CNT_W - 1;
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(SP_DATA_W - 1);

    sp_state_t state, state_d;

    logic                 sclk_q;
    logic                 rise, fall;
    logic [BIT_W-1:0]     bitcnt;
    logic [CNT_W-1:0]     bytecnt, nbytes;
    logic                 rw_q;
    logic [ADDR_W-1:0]    addr_q;
    logic [SP_DATA_W-1:0] sh_in, sh_out, in_next, out_word;
    logic                 dout_q;
    logic                 step_lsb;
    logic                 wr_en_q;
    logic [ADDR_W-1:0]    wr_addr_q;
    logic [SP_DATA_W-1:0] wr_data_q;

    assign rise     = sclk & ~sclk_q;
    assign fall     = ~sclk & sclk_q;
    assign in_next  = cfg_lsb ? {sdi, sh_in[SP_DATA_W-1:1]} : {sh_in[SP_DATA_W-2:0], sdi};
    assign out_word = (bitcnt == '0) ? rd_data : sh_out;
    // Step direction follows a configuration written by this very byte.
    assign step_lsb = (!rw_q && addr_q == '0) ? in_next[CFG_LSB_BIT] : cfg_lsb;

    // Next-state logic
    always_comb begin
        state_d = state;
        if (cs_n) begin
            state_d = S_IDLE;
        end else begin
            unique case (state)
                S_IDLE:  state_d = S_INSTR;
                S_INSTR: if (rise && bitcnt == LAST_BIT) state_d = S_DATA;
                S_DATA:  if (rise && bitcnt == LAST_BIT && bytecnt == nbytes) state_d = S_DONE;
                S_DONE:  state_d = S_DONE;
                default: state_d = S_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_d;
    end

    // Shift, count and address datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q    <= 1'b0;
            bitcnt    <= '0;
            bytecnt   <= '0;
            nbytes    <= '0;
            rw_q      <= 1'b0;
            addr_q    <= '0;
            sh_in     <= '0;
            sh_out    <= '0;
            dout_q    <= 1'b0;
            wr_en_q   <= 1'b0;
            wr_addr_q <= '0;
            wr_data_q <= '0;
        end else begin
            sclk_q  <= sclk;
            wr_en_q <= 1'b0;
            if (state == S_IDLE) begin
                bitcnt  <= '0;
                bytecnt <= '0;
            end
            if (!cs_n && rise && (state == S_INSTR || state == S_DATA)) begin
                sh_in  <= in_next;
                bitcnt <= bitcnt + 1'b1;
                if (bitcnt == LAST_BIT) begin
                    if (state == S_INSTR) begin
                        rw_q    <= in_next[RW_POS];
                        nbytes  <= in_next[N_HI:N_LO];
                        addr_q  <= in_next[ADDR_W-1:0];
                        bytecnt <= '0;
                    end else begin
                        if (!rw_q) begin
                            wr_en_q   <= 1'b1;
                            wr_addr_q <= addr_q;
                            wr_data_q <= in_next;
                        end
                        addr_q  <= step_lsb ? addr_q + 1'b1 : addr_q - 1'b1;
                        bytecnt <= bytecnt + 1'b1;
                    end
                end
            end
            if (!cs_n && fall && state == S_DATA && rw_q) begin
                dout_q <= cfg_lsb ? out_word[0] : out_word[SP_DATA_W-1];
                sh_out <= cfg_lsb ? (out_word >> 1) : (out_word << 1);
            end
        end
    end

    // Outputs
    always_comb begin
        rd_addr = addr_q;
        wr_en   = wr_en_q;
        wr_addr = wr_addr_q;
        wr_data = wr_data_q;
        dout    = dout_q;
        sdio_oe = (state == S_DATA) && rw_q && !cfg_4w;
        sdo_oe  = (state == S_DATA) && rw_q &&  cfg_4w;
    end

    // A high chip select always brings the controller back to IDLE.
    assert_abort_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> state == S_IDLE);

    // Register writes only come out of a data phase under chip select.
    assert_write_from_data_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ($past(state) == S_DATA && !$past(cs_n)));

    // Read data moves only on a detected SCLK falling edge.
    assert_dout_on_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !fall |=> $stable(dout_q));

endmodule

// File: rtl/serport_top.sv
module serport_top
    import serport_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int CNT_W  = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              cs_n,
    input  logic                              sclk,
    input  logic                              sdio_in,
    output logic                              sdio_out,
    output logic                              sdio_oe,
    output logic                              sdo,
    output logic                              sdo_oe,
    output logic [(1<<ADDR_W)*SP_DATA_W-1:0]  reg_flat
);
    logic                 wr_en, cfg_lsb, cfg_4w, dout;
    logic [ADDR_W-1:0]    wr_addr, rd_addr;
    logic [SP_DATA_W-1:0] wr_data, rd_data;

    serport_fsm #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n    (cs_n),
        .sclk    (sclk),
        .sdi     (sdio_in),
        .cfg_lsb (cfg_lsb),
        .cfg_4w  (cfg_4w),
        .rd_data (rd_data),
        .rd_addr (rd_addr),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .dout    (dout),
        .sdio_oe (sdio_oe),
        .sdo_oe  (sdo_oe)
    );

    serport_regbank #(.ADDR_W(ADDR_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .cfg_lsb  (cfg_lsb),
        .cfg_4w   (cfg_4w),
        .reg_flat (reg_flat)
    );

    assign sdio_out = dout;
    assign sdo      = dout;

endmodule

// File: tb/tb_serport_top.sv
module tb_serport_top;
    localparam int NREG = 32;

    logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0, sdio_in = 1'b0;
    logic sdio_out, sdio_oe, sdo, sdo_oe;
    logic [NREG*8-1:0] reg_flat;

    int checks = 0, errors = 0;
    logic [7:0] model [NREG];
    bit b_lsb = 1'b0, b_4w = 1'b0;
    logic [7:0] exp_q [$];
    bit rd_phase = 1'b0;
    int mon_bits = 0;
    logic [7:0] mon_byte = 8'h00;
    string mon_req = "R11";
    bit finished = 1'b0;

    always #10 clk = ~clk;

    serport_top dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdio_in(sdio_in),
        .sdio_out(sdio_out), .sdio_oe(sdio_oe), .sdo(sdo), .sdo_oe(sdo_oe),
        .reg_flat(reg_flat)
    );

    function automatic logic [7:0] tb_default(input int k);
        logic [7:0] p;
        p = 8'(k * 29);
        return (k == 0) ? 8'h00 : (p ^ 8'hA5);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Monitor: samples read data on each SCLK rise and compares with the scoreboard.
    always @(posedge sclk) begin : mon
        logic line;
        logic [7:0] e;
        if (rd_phase) begin
            line = b_4w ? sdo : sdio_out;
            chk(b_4w ? (sdo_oe && !sdio_oe) : (sdio_oe && !sdo_oe), "R8", "output enable",
                {sdio_oe, sdo_oe}, b_4w ? 2'b01 : 2'b10);
            mon_byte = b_lsb ? {line, mon_byte[7:1]} : {mon_byte[6:0], line};
            mon_bits++;
            if (mon_bits == 8) begin
                mon_bits = 0;
                if (exp_q.size() == 0) begin
                    chk(1'b0, mon_req, "unexpected read byte", mon_byte, 0);
                end else begin
                    e = exp_q.pop_front();
                    chk(mon_byte == e, mon_req, "read byte", mon_byte, e);
                end
            end
        end
    end

    task automatic half();
        repeat (4) @(negedge clk);
    endtask

    task automatic send_bit(input bit b);
        @(negedge clk);
        sclk = 1'b0; sdio_in = b;
        half();
        sclk = 1'b1;
        half();
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) send_bit(b_lsb ? v[i] : v[7-i]);
    endtask

    task automatic model_write(input logic [4:0] a, input logic [7:0] v);
        if (a == 5'd0) begin
            model[0] = v & 8'hDF;
            b_lsb = v[6];
            b_4w  = v[7];
            if (v[5]) for (int k = 1; k < NREG; k++) model[k] = tb_default(k);
        end else begin
            model[a] = v;
        end
    endtask

    task automatic xfer(input bit rw, input int n, input logic [4:0] a,
                        input logic [31:0] d, input string req);
        logic [4:0] ad;
        ad = a;
        mon_req = req;
        @(negedge clk);
        cs_n = 1'b0;
        half();
        send_byte({rw, 2'(n - 1), a});
        for (int k = 0; k < n; k++) begin
            if (rw) begin
                exp_q.push_back(model[ad]);
                rd_phase = 1'b1;
                send_byte(8'h00);
            end else begin
                send_byte(d[8*k +: 8]);
                model_write(ad, d[8*k +: 8]);
            end
            ad = b_lsb ? ad + 5'd1 : ad - 5'd1;
        end
        rd_phase = 1'b0;
        @(negedge clk);
        sclk = 1'b0;
        half();
        cs_n = 1'b1;
        half();
        half();
        if (rw) chk(exp_q.size() == 0, req, "read bytes missing", exp_q.size(), 0);
    endtask

    task automatic check_bank(input string req);
        for (int k = 0; k < NREG; k++)
            chk(reg_flat[k*8 +: 8] == model[k], req, $sformatf("register %0d", k),
                reg_flat[k*8 +: 8], model[k]);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            chk(1'b0, "WDOG", "watchdog expired", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : driver
        for (int k = 0; k < NREG; k++) model[k] = tb_default(k);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R10: reset state
        chk(!sdio_oe && !sdo_oe, "R10", "output enables after reset", {sdio_oe, sdo_oe}, 0);
        check_bank("R10");

        // R2 / R1: MSB-first, 3 bytes, address decrements 5,4,3
        xfer(1'b0, 3, 5'h05, 32'h0033_2211, "R2");
        check_bank("R2");
        xfer(1'b1, 3, 5'h05, 32'h0, "R2");

        // R1: single byte write touches only its register
        xfer(1'b0, 1, 5'h14, 32'h0000_00C3, "R1");
        check_bank("R1");

        // R4: decrement wrap 0x00 -> 0x1F on a read
        xfer(1'b1, 2, 5'h00, 32'h0, "R4");

        // R5: switch to LSB-first in mid-transfer; second byte goes to 0x01 LSB-first
        xfer(1'b0, 2, 5'h00, 32'h0000_5C40, "R5");
        check_bank("R5");

        // R3: LSB-first, 4 bytes incrementing
        xfer(1'b0, 4, 5'h0A, 32'h8D7E_6F19, "R3");
        check_bank("R3");
        xfer(1'b1, 4, 5'h0A, 32'h0, "R3");

        // R4: increment wrap 0x1F -> 0x00 on a write
        xfer(1'b0, 2, 5'h1F, 32'h0000_409E, "R4");
        check_bank("R4");
        xfer(1'b1, 2, 5'h1F, 32'h0, "R4");

        // R8: 4-wire read, LSB-first
        xfer(1'b0, 1, 5'h00, 32'h0000_00C0, "R8");
        xfer(1'b1, 4, 5'h09, 32'h0, "R8");

        // R11: write then read back new contents
        xfer(1'b0, 1, 5'h0C, 32'h0000_00A1, "R11");
        xfer(1'b1, 2, 5'h0B, 32'h0, "R11");

        // R6: software reset keeps configuration, bit 5 reads 0
        xfer(1'b0, 1, 5'h00, 32'h0000_00E3, "R6");
        check_bank("R6");
        xfer(1'b1, 2, 5'h05, 32'h0, "R6");

        // R7: host assumes MSB-first while port is LSB-first 4-wire
        b_lsb = 1'b0;
        xfer(1'b0, 1, 5'h00, 32'h0000_0024, "R7");
        check_bank("R7");
        xfer(1'b1, 1, 5'h05, 32'h0, "R7");

        // R7: host assumes LSB-first while port is MSB-first 3-wire
        xfer(1'b0, 1, 5'h07, 32'h0000_0055, "R7");
        b_lsb = 1'b1;
        xfer(1'b0, 1, 5'h00, 32'h0000_00A5, "R7");
        check_bank("R7");
        xfer(1'b1, 2, 5'h05, 32'h0, "R7");

        // R9: abort after five instruction bits, then a clean transfer
        @(negedge clk);
        cs_n = 1'b0;
        half();
        for (int i = 0; i < 5; i++) send_bit(1'b0);
        @(negedge clk);
        sclk = 1'b0;
        cs_n = 1'b1;
        half();
        check_bank("R9");
        xfer(1'b0, 1, 5'h03, 32'h0000_003C, "R9");
        check_bank("R9");
        xfer(1'b1, 1, 5'h03, 32'h0, "R9");

        chk(!sdio_oe && !sdo_oe, "R8", "output enables idle", {sdio_oe, sdo_oe}, 0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule